// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block drives the three reset controls of one serial transceiver channel from a single system clock. After a power-up reset or a restart request, it holds the receiver analog circuitry powered down for a programmable number of system clock cycles. During that time both digital resets are held. Once the power-down ends, the transmitter digital reset is released after its minimum hold. The receiver digital reset is released only after the receiver reports frequency lock and its own minimum hold has elapsed. Minimum holds are counted in parallel clock cycles, which the block sees as a one-cycle pulse on `pclk_tick` per parallel clock cycle.

While the channel runs, the block watches two inputs. The first is the flag that reports a pointer collision in the phase-compensation FIFO. The second is the lock indication. On a collision it re-issues both digital resets for their minimum holds and leaves the analog power-down released. On a loss of lock it reasserts only the receiver digital reset and waits for lock again. Both inputs pass through two-flop synchronizers first. A ready output reports that the channel has settled. Any reset output that a configuration parameter disables is held at its inactive level.

Top module: `xcvr_rst_seq`

## Requirements
- R1: `rx_analog_pd` is active-high. It is high during power-up reset and after a restart, and both digital reset outputs are high for as long as it is high.
- R2: `rx_analog_pd` falls on the PD_CYCLES-th rising edge after power-up reset release. After a restart, it falls on the PD_CYCLES-th rising edge after the edge that samples `restart_req`.
- R3: `rx_digital_rst` stays high while the synchronized `freq_lock_in` is low, however long that lasts.
- R4: `rx_digital_rst` stays high for at least RX_MIN_TICKS cycles in which `pclk_tick` is high.
- R5: `tx_digital_rst` stays high for at least TX_MIN_TICKS `pclk_tick` cycles. It is then released without waiting for lock.
- R6: A rising edge of the synchronized `fifo_collide_in` while the channel runs reasserts both digital resets and leaves `rx_analog_pd` low. With lock present, each reset is then held for exactly its minimum tick count.
- R7: Collision edges that arrive while the re-issued resets are still high are ignored. A collision edge after both resets are released is acted on again.
- R8: A loss of lock after the receiver reset has been released reasserts `rx_digital_rst` only. It is released again after lock returns and the minimum hold has elapsed.
- R9: `chan_ready` is high only when all three resets are low and lock is present. It drops on a collision, a loss of lock or a restart.
- R10: `restart_req` starts the whole sequence again from the analog power-down. It takes priority over a collision edge in the same cycle.
- R11: A reset output whose enable parameter is 0 is held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| pclk_tick | input | 1 | One-cycle pulse per parallel clock cycle |
| freq_lock_in | input | 1 | Receiver frequency-lock indication (asynchronous) |
| fifo_collide_in | input | 1 | FIFO pointer-collision flag (asynchronous) |
| restart_req | input | 1 | Synchronous request to restart the full sequence |
| rx_analog_pd | output | 1 | Receiver analog power-down, high = powered down |
| rx_digital_rst | output | 1 | Receiver digital reset, active-high |
| tx_digital_rst | output | 1 | Transmitter digital reset, active-high |
| chan_ready | output | 1 | Channel settled: resets released and lock present |

## Verification
Two events can fall in the same cycle. A collision edge can leave the synchronizer in the same cycle that the lock indication drops. A collision edge can also coincide with a restart request. The bench changes lock and the collision flag on the same clock so that both synchronizers deliver together. It then requires both digital resets high, with the transmitter reset showing that the collision was not masked by the lock loss. For the restart case it raises `restart_req` exactly two cycles after the collision flag, which is the cycle the synchronized edge appears. It then requires a fresh power-down of full length, which shows that the restart won.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic {
    PH_PWRDN   = 1'b0,
    PH_DIGITAL = 1'b1
  } xrs_phase_e;

  // bits needed to hold the values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // a hold is complete once the counted ticks reach the minimum
  function automatic bit hold_met(input int unsigned ticks, input int unsigned min_ticks);
    return ticks >= min_ticks;
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= d;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
  parameter int CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  import xrs_pkg::*;

  localparam int CW = cnt_bits(CYCLES);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= START;
    else if (load)               cnt <= START;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/xrs_hold.sv
module xrs_hold #(
  parameter int MIN_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic allow,
  output logic rst_o
);
  import xrs_pkg::*;

  localparam int CW = cnt_bits(MIN_TICKS);

  logic [CW-1:0] ticks;
  logic          met;

  assign met = hold_met(int'(ticks), MIN_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_o <= 1'b1;
      ticks <= '0;
    end else if (start) begin
      rst_o <= 1'b1;
      ticks <= '0;
    end else if (rst_o) begin
      if (met && allow) rst_o <= 1'b0;
      else if (tick && !met) ticks <= ticks + 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int PD_CYCLES    = 125000,
  parameter int RX_MIN_TICKS = 4,
  parameter int TX_MIN_TICKS = 4,
  parameter int SYNC_STAGES  = 2,
  parameter bit EN_ANALOG_PD = 1'b1,
  parameter bit EN_RX_DIG    = 1'b1,
  parameter bit EN_TX_DIG    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk_tick,
  input  logic freq_lock_in,
  input  logic fifo_collide_in,
  input  logic restart_req,
  output logic rx_analog_pd,
  output logic rx_digital_rst,
  output logic tx_digital_rst,
  output logic chan_ready
);
  import xrs_pkg::*;

  xrs_phase_e phase;
  logic [1:0] sync_q;
  logic lock_s, col_s, col_s_d, col_rise;
  logic pd_active, pd_done;
  logic rx_rst_i, tx_rst_i, both_released;
  logic col_event, lock_loss, armed;
  logic start_rx, start_tx, allow_rx, allow_tx;

  xrs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({fifo_collide_in, freq_lock_in}),
    .q(sync_q)
  );
  assign lock_s = sync_q[0];
  assign col_s  = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_s_d <= 1'b0;
    else        col_s_d <= col_s;
  end
  assign col_rise = col_s && !col_s_d;

  xrs_timer #(.CYCLES(PD_CYCLES)) u_pd_timer (
    .clk(clk), .rst_n(rst_n),
    .load(restart_req),
    .run(pd_active),
    .done(pd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= PH_PWRDN;
    else if (restart_req)           phase <= PH_PWRDN;
    else if (pd_active && pd_done)  phase <= PH_DIGITAL;
  end

  assign pd_active     = (phase == PH_PWRDN);
  assign both_released = !rx_rst_i && !tx_rst_i;

  // named events for the checker
  assign col_event = col_rise && armed && !pd_active && !restart_req;
  assign lock_loss = !pd_active && !rx_rst_i && !lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           armed <= 1'b1;
    else if (col_event)                   armed <= 1'b0;
    else if (both_released && !pd_active) armed <= 1'b1;
  end

  assign start_rx = restart_req || pd_active || col_event || lock_loss;
  assign start_tx = restart_req || pd_active || col_event;
  assign allow_rx = !pd_active && lock_s;
  assign allow_tx = !pd_active;

  xrs_hold #(.MIN_TICKS(RX_MIN_TICKS)) u_rx_hold (
    .clk(clk), .rst_n(rst_n), .start(start_rx), .tick(pclk_tick),
    .allow(allow_rx), .rst_o(rx_rst_i)
  );

  xrs_hold #(.MIN_TICKS(TX_MIN_TICKS)) u_tx_hold (
    .clk(clk), .rst_n(rst_n), .start(start_tx), .tick(pclk_tick),
    .allow(allow_tx), .rst_o(tx_rst_i)
  );

  assign chan_ready = !pd_active && both_released && lock_s;

  if (EN_ANALOG_PD) begin : g_pd_on
    assign rx_analog_pd = pd_active;
  end else begin : g_pd_off
    assign rx_analog_pd = 1'b0;
  end

  if (EN_RX_DIG) begin : g_rx_on
    assign rx_digital_rst = rx_rst_i;
  end else begin : g_rx_off
    assign rx_digital_rst = 1'b0;
  end

  if (EN_TX_DIG) begin : g_tx_on
    assign tx_digital_rst = tx_rst_i;
  end else begin : g_tx_off
    assign tx_digital_rst = 1'b0;
  end

endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
  parameter int RX_MIN = 4,
  parameter int TX_MIN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic pclk_tick,
  input logic pd_i,
  input logic rx_i,
  input logic tx_i,
  input logic lock_s,
  input logic col_event,
  input logic lock_loss,
  input logic restart_req,
  input logic chan_ready
);

  logic [7:0] rx_ticks, tx_ticks;
  logic       pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ticks <= '0;
      tx_ticks <= '0;
      pending  <= 1'b0;
    end else begin
      if (!rx_i) rx_ticks <= '0;
      else if (pclk_tick && rx_ticks != 8'hFF) rx_ticks <= rx_ticks + 8'd1;
      if (!tx_i) tx_ticks <= '0;
      else if (pclk_tick && tx_ticks != 8'hFF) tx_ticks <= tx_ticks + 8'd1;
      if (col_event) pending <= 1'b1;
      else if (!rx_i && !tx_i) pending <= 1'b0;
    end
  end

  assert_pd_holds_dig_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |-> (rx_i && tx_i));

  assert_rx_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_i) |-> ($past(lock_s) && !pd_i));

  assert_rx_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_i) |-> (int'(rx_ticks) >= RX_MIN));

  assert_tx_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_i) |-> (int'(tx_ticks) >= TX_MIN));

  assert_col_reissue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_event |=> (rx_i && tx_i && !pd_i));

  assert_col_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_event |-> !pending);

  assert_lock_loss_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_loss |=> (rx_i && !pd_i));

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_event || lock_loss || restart_req) |=> !chan_ready);

  assert_restart_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> pd_i);

endmodule

bind xcvr_rst_seq xrs_chk #(.RX_MIN(RX_MIN_TICKS), .TX_MIN(TX_MIN_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick),
  .pd_i(pd_active), .rx_i(rx_rst_i), .tx_i(tx_rst_i),
  .lock_s(lock_s), .col_event(col_event), .lock_loss(lock_loss),
  .restart_req(restart_req), .chan_ready(chan_ready)
);

// File: tb/xcvr_rst_seq_test.sv
module xcvr_rst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int PD  = 20;
  localparam int RXM = 4;
  localparam int TXM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk_tick = 1'b0;
  logic lock = 1'b0, col = 1'b0, restart = 1'b0;
  logic pd, rxr, txr, rdy;
  logic d_pd, d_rx, d_tx, d_rdy;
  int checks = 0, errors = 0;
  int div = 0;
  bit dis_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    div <= (div == 2) ? 0 : div + 1;
    pclk_tick <= (div == 2);
  end

  xcvr_rst_seq #(.PD_CYCLES(PD), .RX_MIN_TICKS(RXM), .TX_MIN_TICKS(TXM)) uut (
    .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick), .freq_lock_in(lock),
    .fifo_collide_in(col), .restart_req(restart), .rx_analog_pd(pd),
    .rx_digital_rst(rxr), .tx_digital_rst(txr), .chan_ready(rdy)
  );

  xcvr_rst_seq #(.PD_CYCLES(PD), .RX_MIN_TICKS(RXM), .TX_MIN_TICKS(TXM),
                 .EN_ANALOG_PD(1'b0), .EN_TX_DIG(1'b0)) uut_dis (
    .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick), .freq_lock_in(lock),
    .fifo_collide_in(col), .restart_req(restart), .rx_analog_pd(d_pd),
    .rx_digital_rst(d_rx), .tx_digital_rst(d_tx), .chan_ready(d_rdy)
  );

  // tick counts over each high episode of the digital resets
  int rx_run = 0, tx_run = 0, rx_last = 0, tx_last = 0;
  logic rx_prev = 1'b0, tx_prev = 1'b0;
  always @(negedge clk) begin
    if (rxr === 1'b1) begin
      if (!rx_prev) rx_run = 0;
      if (pclk_tick) rx_run++;
    end else if (rx_prev) rx_last = rx_run;
    rx_prev = (rxr === 1'b1);
    if (txr === 1'b1) begin
      if (!tx_prev) tx_run = 0;
      if (pclk_tick) tx_run++;
    end else if (tx_prev) tx_last = tx_run;
    tx_prev = (txr === 1'b1);
    if (d_pd !== 1'b0 || d_tx !== 1'b0) dis_bad = 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lo);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s: actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  // sel 0: rx equals v, 1: both digital resets low
  task automatic wait_for(input string tag, input int sel, input logic v, input int lim);
    bit ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (sel == 0 && rxr === v) begin ok = 1'b1; break; end
      if (sel == 1 && rxr === 1'b0 && txr === 1'b0) begin ok = 1'b1; break; end
    end
    chk(tag, int'(ok), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pd", int'(pd), 1);
    chk("R1 reset rx", int'(rxr), 1);
    chk("R1 reset tx", int'(txr), 1);
    chk("R9 reset ready", int'(rdy), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_pd_release();
    repeat (PD-1) @(negedge clk);
    chk("R2 pd still high", int'(pd), 1);
    chk("R1 rx held in pd", int'(rxr), 1);
    chk("R1 tx held in pd", int'(txr), 1);
    @(negedge clk);
    chk("R2 pd released", int'(pd), 0);
  endtask

  task automatic t_lock_wait();
    repeat (60) @(negedge clk);
    chk("R3 rx held without lock", int'(rxr), 1);
    chk("R5 tx released without lock", int'(txr), 0);
    chk_ge("R5 tx hold ticks", tx_last, TXM);
    chk("R9 not ready without lock", int'(rdy), 0);
    lock = 1'b1;
    wait_for("R3 rx released after lock", 0, 1'b0, 30);
    @(negedge clk);
    chk_ge("R4 rx hold ticks", rx_last, RXM);
    chk("R9 ready after release", int'(rdy), 1);
  endtask

  task automatic t_collision();
    col = 1'b1;
    wait_for("R6 rx reissued", 0, 1'b1, 8);
    chk("R6 tx reissued", int'(txr), 1);
    chk("R6 pd stays low", int'(pd), 0);
    chk("R9 ready drops on collision", int'(rdy), 0);
    wait_for("R6 release", 1, 1'b0, 40);
    @(negedge clk);
    chk("R6 rx exact ticks", rx_last, RXM);
    chk("R6 tx exact ticks", tx_last, TXM);
    chk("R9 ready back", int'(rdy), 1);
    col = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collision_ignore();
    col = 1'b1;
    wait_for("R7 first event", 0, 1'b1, 8);
    col = 1'b0;
    repeat (3) @(negedge clk);
    col = 1'b1;
    wait_for("R7 release", 1, 1'b0, 40);
    @(negedge clk);
    chk("R7 second edge ignored", rx_last, RXM);
    chk("R7 tx not extended", tx_last, TXM);
    col = 1'b0;
    repeat (4) @(negedge clk);
    col = 1'b1;
    wait_for("R7 rearmed event", 0, 1'b1, 8);
    chk("R7 rearmed tx", int'(txr), 1);
    wait_for("R7 rearm release", 1, 1'b0, 40);
    col = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lock_loss();
    lock = 1'b0;
    wait_for("R8 rx on lock loss", 0, 1'b1, 8);
    chk("R8 tx untouched", int'(txr), 0);
    chk("R8 pd untouched", int'(pd), 0);
    chk("R9 ready drops on lock loss", int'(rdy), 0);
    repeat (30) @(negedge clk);
    chk("R8 rx waits for lock", int'(rxr), 1);
    lock = 1'b1;
    wait_for("R8 rx released again", 0, 1'b0, 30);
    @(negedge clk);
    chk_ge("R8 rx hold ticks", rx_last, RXM);
    chk("R9 ready after relock", int'(rdy), 1);
  endtask

  task automatic t_coincide();
    lock = 1'b0;
    col  = 1'b1;
    wait_for("R6 coincide rx", 0, 1'b1, 8);
    chk("R6 coincide tx", int'(txr), 1);
    chk("R6 coincide pd", int'(pd), 0);
    lock = 1'b1;
    wait_for("R6 coincide release", 1, 1'b0, 40);
    @(negedge clk);
    chk("R9 coincide ready", int'(rdy), 1);
    col = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_restart_col();
    col = 1'b1;
    @(negedge clk);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R10 restart pd", int'(pd), 1);
    chk("R10 restart rx", int'(rxr), 1);
    chk("R10 restart tx", int'(txr), 1);
    chk("R9 ready drops on restart", int'(rdy), 0);
    repeat (PD-1) @(negedge clk);
    chk("R2 restart pd full length", int'(pd), 1);
    @(negedge clk);
    chk("R2 restart pd released", int'(pd), 0);
    wait_for("R10 release after restart", 1, 1'b0, 40);
    @(negedge clk);
    chk("R9 ready after restart", int'(rdy), 1);
    col = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_disabled();
    chk("R11 disabled outputs low", int'(dis_bad), 0);
    chk("R11 enabled rx still works", int'(d_rx), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pd_release();
    t_lock_wait();
    t_collision();
    t_collision_ignore();
    t_lock_loss();
    t_coincide();
    t_restart_col();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule